// File: doc/BRIEF.md
# Two-Register Counter Machine Core

This block is a very small processor core. It has two general registers, a 4-bit program counter and one 16-word by 8-bit memory that holds both program and data. Each 8-bit instruction has a 3-bit opcode in bits [7:5], a register select in bit [4] (0 picks register 0, 1 picks register 1) and a 4-bit address in bits [3:0]. The core can step a register up or down by one, jump when register 0 is zero, copy a register into memory and copy a memory word into a register. All register and memory updates pass through one arithmetic unit. That unit has add, subtract and pass modes, and its second operand is the constant 1. An operand multiplexer picks either a register or the memory word as the unit's input. A result demultiplexer sends the unit's output to either a register or memory.

A two-state sequencer runs every instruction. In state FETCH the word at the program counter is latched into the instruction register, and the transition FETCH→EXEC always follows. In state EXEC the latched word is decoded and carried out, and the transition EXEC→FETCH always follows. Register writes, memory writes and the program counter update all take effect on the clock edge that ends EXEC. A testbench or loader fills memory through the preload port while the core is held in reset. Debug outputs show the program counter and both registers.

Top module: `cmach_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and both registers become 0 and the sequencer enters FETCH.
- R2: Each instruction takes exactly two cycles, FETCH then EXEC. The program counter and the registers keep their values through the FETCH cycle and change only on the edge that ends EXEC.
- R3: Opcode 000 adds 1 to the register chosen by bit [4], and the value 2^N-1 wraps to 0 (N = `REG_W`, default 8).
- R4: Opcode 001 subtracts 1 from the chosen register, and the value 0 wraps to 2^N-1.
- R5: Opcode 010 loads the program counter with bits [3:0] when register 0 is zero. When register 0 is nonzero the program counter advances by one instead. Bit [4] plays no part.
- R6: Opcode 100 writes the low 8 bits of the chosen register into the memory word at bits [3:0]. Neither register changes.
- R7: Opcode 101 loads the chosen register with the memory word at bits [3:0], zero-extended.
- R8: Every instruction that is not a taken jump advances the program counter by one, and 15 wraps to 0.
- R9: Opcodes 011, 110 and 111 change nothing except the program counter, which advances by one, whatever bits [4:0] hold.
- R10: A rising edge with `pre_we` high writes `pre_data` into the memory word at `pre_addr`. If a store falls in the same cycle, the preload write takes precedence.
- R11: Program and data share the same memory. A word changed by a store is the word fetched the next time the program counter reaches its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 4 | Preload word address |
| pre_data | input | 8 | Preload word value |
| dbg_pc | output | 4 | Current program counter |
| dbg_r0 | output | REG_W | Register 0 |
| dbg_r1 | output | REG_W | Register 1 |

## Verification
The assertions assume that memory is written only while `rst` is high. Under that assumption a preload never collides with a store, so every word the core fetches or loads comes either from the loader or from its own stores. They also assume that reset is held for more than one cycle before the program starts, so that `$stable` and `$past` compare values that exist after reset. Each scenario in the bench therefore first fills all 16 words with the reset line held high. It fills unused words with a no-operation, so a run that goes past the end of its program does nothing to the registers. It then releases reset on a falling edge and counts whole two-cycle instructions before it samples the debug outputs.

// File: rtl/cmach_pkg.sv
package cmach_pkg;

    localparam int INSN_W = 8;
    localparam int OP_W   = 3;
    localparam int ADR_W  = 4;
    localparam int DEPTH  = 1 << ADR_W;
    localparam int OP_LSB = INSN_W - OP_W;
    localparam int RS_BIT = OP_LSB - 1;

    typedef enum logic [OP_W-1:0] {
        OP_INC  = 3'b000,
        OP_DEC  = 3'b001,
        OP_BRZ  = 3'b010,
        OP_NOPA = 3'b011,
        OP_STR  = 3'b100,
        OP_LDR  = 3'b101,
        OP_NOPB = 3'b110,
        OP_NOPC = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        AU_ADD  = 2'd0,
        AU_SUB  = 2'd1,
        AU_PASS = 2'd2
    } au_mode_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        au_mode_e         mode;
        logic             src_mem;
        logic             wr_reg;
        logic             wr_mem;
        logic             branch;
        logic             rsel;
        logic [ADR_W-1:0] addr;
    } ctl_t;

endpackage

// File: rtl/cmach_decode.sv
module cmach_decode
    import cmach_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output ctl_t              ctl
);

    opcode_e op;

    assign op = opcode_e'(insn[INSN_W-1:OP_LSB]);

    always_comb begin
        ctl         = '0;
        ctl.mode    = AU_PASS;
        ctl.rsel    = insn[RS_BIT];
        ctl.addr    = insn[ADR_W-1:0];
        unique case (op)
            OP_INC: begin
                ctl.mode   = AU_ADD;
                ctl.wr_reg = 1'b1;
            end
            OP_DEC: begin
                ctl.mode   = AU_SUB;
                ctl.wr_reg = 1'b1;
            end
            OP_BRZ: begin
                ctl.branch = 1'b1;
            end
            OP_STR: begin
                ctl.wr_mem = 1'b1;
            end
            OP_LDR: begin
                ctl.src_mem = 1'b1;
                ctl.wr_reg  = 1'b1;
            end
            OP_NOPA, OP_NOPB, OP_NOPC: begin
                ctl.mode = AU_PASS;
            end
        endcase
    end

    // R9: the spare opcodes never request a write or a jump
    always_comb begin
        if (op == OP_NOPA || op == OP_NOPB || op == OP_NOPC) begin
            p_spare_inert_r9: assert (!ctl.wr_reg && !ctl.wr_mem && !ctl.branch);
        end
    end

endmodule

// File: rtl/cmach_au.sv
module cmach_au
    import cmach_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  au_mode_e     mode,
    output logic [W-1:0] y
);

    localparam logic [W-1:0] STEP = W'(1);

    always_comb begin
        unique case (mode)
            AU_ADD:  y = a + STEP;
            AU_SUB:  y = a - STEP;
            AU_PASS: y = a;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/cmach_seq.sv
module cmach_seq
    import cmach_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [ADR_W-1:0] target,
    output phase_e           phase,
    output logic [ADR_W-1:0] pc
);

    phase_e           phase_nx;
    logic [ADR_W-1:0] pc_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
            pc    <= '0;
        end else begin
            phase <= phase_nx;
            pc    <= pc_nx;
        end
    end

    always_comb begin
        phase_nx = phase;
        pc_nx    = pc;
        unique case (phase)
            PH_FETCH: phase_nx = PH_EXEC;
            PH_EXEC: begin
                phase_nx = PH_FETCH;
                pc_nx    = take ? target : pc + ADR_W'(1);
            end
        endcase
    end

    p_exec_after_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FETCH |=> phase == PH_EXEC);
    p_fetch_after_exec_r2: assert property (@(posedge clk) disable iff (rst)
        phase == PH_EXEC |=> phase == PH_FETCH);
    p_pc_still_in_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FETCH |=> $stable(pc));
    p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && !take) |=> pc == ADR_W'($past(pc) + 1'b1));
    p_pc_jump_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && take) |=> pc == $past(target));

endmodule

// File: rtl/cmach_mem.sv
module cmach_mem
    import cmach_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [ADR_W-1:0]  ld_addr,
    input  logic [INSN_W-1:0] ld_data,
    input  logic              st_we,
    input  logic [ADR_W-1:0]  st_addr,
    input  logic [INSN_W-1:0] st_data,
    input  logic [ADR_W-1:0]  rd_addr,
    output logic [INSN_W-1:0] rd_data
);

    logic [INSN_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_we) begin
            cells[ld_addr] <= ld_data;
        end else if (st_we) begin
            cells[st_addr] <= st_data;
        end
    end

    assign rd_data = cells[rd_addr];

    p_store_lands_r6: assert property (@(posedge clk) disable iff (rst)
        (st_we && !ld_we) |=> cells[$past(st_addr)] == $past(st_data));
    p_preload_lands_r10: assert property (@(posedge clk)
        ld_we |=> cells[$past(ld_addr)] == $past(ld_data));

endmodule

// File: rtl/cmach_core.sv
module cmach_core
    import cmach_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic [ADR_W-1:0]  pre_addr,
    input  logic [INSN_W-1:0] pre_data,
    output logic [ADR_W-1:0]  dbg_pc,
    output logic [REG_W-1:0]  dbg_r0,
    output logic [REG_W-1:0]  dbg_r1
);

    localparam int NREG = 2;

    phase_e            phase;
    logic [ADR_W-1:0]  pc;
    logic [INSN_W-1:0] ir;
    ctl_t              ctl;
    logic [REG_W-1:0]  regs [NREG];
    logic [INSN_W-1:0] mem_q;
    logic [ADR_W-1:0]  rd_addr;
    logic [REG_W-1:0]  mem_ext;
    logic [REG_W-1:0]  au_a;
    logic [REG_W-1:0]  au_y;
    logic [INSN_W-1:0] st_word;
    logic              in_exec;
    logic              take;
    logic              st_we;
    logic              reg_we;

    cmach_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .target (ctl.addr),
        .phase  (phase),
        .pc     (pc)
    );

    cmach_decode u_dec (
        .insn (ir),
        .ctl  (ctl)
    );

    cmach_au #(.W(REG_W)) u_au (
        .a    (au_a),
        .mode (ctl.mode),
        .y    (au_y)
    );

    cmach_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .ld_we   (pre_we),
        .ld_addr (pre_addr),
        .ld_data (pre_data),
        .st_we   (st_we),
        .st_addr (ctl.addr),
        .st_data (st_word),
        .rd_addr (rd_addr),
        .rd_data (mem_q)
    );

    assign in_exec = (phase == PH_EXEC);
    assign take    = in_exec && ctl.branch && (regs[0] == '0);
    assign st_we   = in_exec && ctl.wr_mem;
    assign reg_we  = in_exec && ctl.wr_reg;
    assign rd_addr = in_exec ? ctl.addr : pc;

    generate
        if (REG_W == INSN_W) begin : g_same
            assign mem_ext = mem_q;
            assign st_word = au_y;
        end else if (REG_W > INSN_W) begin : g_wide
            assign mem_ext = {{(REG_W-INSN_W){1'b0}}, mem_q};
            assign st_word = au_y[INSN_W-1:0];
        end else begin : g_narrow
            assign mem_ext = mem_q[REG_W-1:0];
            assign st_word = {{(INSN_W-REG_W){1'b0}}, au_y};
        end
    endgenerate

    // operand mux: register or memory word
    assign au_a = ctl.src_mem ? mem_ext : regs[ctl.rsel];

    always_ff @(posedge clk) begin
        if (rst) begin
            ir <= '0;
        end else if (phase == PH_FETCH) begin
            ir <= mem_q;
        end
    end

    // result demux, register side
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (reg_we) begin
            regs[ctl.rsel] <= au_y;
        end
    end

    assign dbg_pc = pc;
    assign dbg_r0 = regs[0];
    assign dbg_r1 = regs[1];

    p_regs_still_in_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FETCH |=> ($stable(regs[0]) && $stable(regs[1])));
    p_inc_r0_r3: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir[INSN_W-1:OP_LSB] == OP_INC && !ir[RS_BIT])
        |=> regs[0] == REG_W'($past(regs[0]) + 1'b1));
    p_dec_r1_r4: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir[INSN_W-1:OP_LSB] == OP_DEC && ir[RS_BIT])
        |=> regs[1] == REG_W'($past(regs[1]) - 1'b1));
    p_store_keeps_regs_r6: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir[INSN_W-1:OP_LSB] == OP_STR)
        |=> ($stable(regs[0]) && $stable(regs[1])));
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir[INSN_W-1:OP_LSB] == OP_LDR)
        |=> regs[$past(ir[RS_BIT])] == $past(mem_ext));

endmodule

// File: tb/sim_cmach_core.sv
module sim_cmach_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [3:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic [3:0] dbg_pc;
    logic [7:0] dbg_r0;
    logic [7:0] dbg_r1;

    logic [7:0] prog [16];
    int ntests = 0;
    int nfail  = 0;

    always #10 clk = ~clk;

    cmach_core u0 (
        .clk      (clk),
        .rst      (rst),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .dbg_pc   (dbg_pc),
        .dbg_r0   (dbg_r0),
        .dbg_r1   (dbg_r1)
    );

    localparam logic [7:0] NOP = 8'h60;

    function automatic logic [7:0] enc(input logic [2:0] op, input logic r, input logic [3:0] a);
        return {op, r, a};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = NOP;
    endtask

    // fill memory under reset, release reset on a falling edge
    task automatic boot();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            pre_we   = 1'b1;
            pre_addr = 4'(i);
            pre_data = prog[i];
            @(negedge clk);
        end
        pre_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (2 * n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_timing();
        clear_prog();
        prog[0] = enc(3'b000, 1'b0, 4'h0);
        boot();
        check("R1 pc after reset", dbg_pc, 0);
        check("R1 r0 after reset", dbg_r0, 0);
        check("R1 r1 after reset", dbg_r1, 0);
        @(posedge clk); @(negedge clk);
        check("R2 pc held in fetch", dbg_pc, 0);
        check("R2 r0 held in fetch", dbg_r0, 0);
        @(posedge clk); @(negedge clk);
        check("R2 pc after exec", dbg_pc, 1);
        check("R2 r0 after exec", dbg_r0, 1);
    endtask

    task automatic t_step();
        clear_prog();
        prog[0] = enc(3'b000, 1'b0, 4'h0);
        prog[1] = enc(3'b000, 1'b0, 4'h0);
        prog[2] = enc(3'b000, 1'b1, 4'h0);
        prog[3] = enc(3'b001, 1'b0, 4'h0);
        boot();
        run(3);
        check("R3 r0 two increments", dbg_r0, 2);
        check("R3 r1 one increment", dbg_r1, 1);
        run(1);
        check("R4 r0 decrement", dbg_r0, 1);
        check("R8 pc after four", dbg_pc, 4);
    endtask

    task automatic t_wrap();
        clear_prog();
        prog[0] = enc(3'b001, 1'b0, 4'h0);
        prog[1] = enc(3'b000, 1'b0, 4'h0);
        prog[2] = enc(3'b001, 1'b1, 4'h0);
        boot();
        run(1);
        check("R4 r0 wraps down", dbg_r0, 255);
        run(1);
        check("R3 r0 wraps up", dbg_r0, 0);
        run(1);
        check("R4 r1 wraps down", dbg_r1, 255);
    endtask

    task automatic t_branch();
        clear_prog();
        prog[0] = enc(3'b010, 1'b1, 4'h5);
        prog[5] = enc(3'b000, 1'b0, 4'h0);
        prog[6] = enc(3'b010, 1'b0, 4'h2);
        boot();
        run(1);
        check("R5 taken when r0 zero", dbg_pc, 5);
        check("R5 r1 untouched by jump", dbg_r1, 0);
        run(1);
        check("R3 r0 after inc", dbg_r0, 1);
        run(1);
        check("R5 not taken when r0 nonzero", dbg_pc, 7);
    endtask

    task automatic t_mem();
        clear_prog();
        prog[0]  = enc(3'b000, 1'b0, 4'h0);
        prog[1]  = enc(3'b000, 1'b0, 4'h0);
        prog[2]  = enc(3'b000, 1'b0, 4'h0);
        prog[3]  = enc(3'b100, 1'b0, 4'hE);
        prog[4]  = enc(3'b101, 1'b1, 4'hE);
        prog[5]  = enc(3'b101, 1'b0, 4'hF);
        prog[15] = 8'hA5;
        boot();
        run(4);
        check("R6 r0 kept by store", dbg_r0, 3);
        check("R6 r1 kept by store", dbg_r1, 0);
        run(1);
        check("R7 r1 loaded from stored word", dbg_r1, 3);
        run(1);
        check("R10 r0 loaded from preloaded word", dbg_r0, 165);
    endtask

    task automatic t_spare();
        clear_prog();
        prog[0] = 8'h7F;
        prog[1] = 8'hDF;
        prog[2] = 8'hFF;
        prog[15] = 8'h11;
        boot();
        run(3);
        check("R9 pc advances", dbg_pc, 3);
        check("R9 r0 unchanged", dbg_r0, 0);
        check("R9 r1 unchanged", dbg_r1, 0);
    endtask

    task automatic t_pc_wrap();
        clear_prog();
        prog[15] = enc(3'b000, 1'b1, 4'h0);
        boot();
        run(16);
        check("R8 pc wraps to zero", dbg_pc, 0);
        check("R8 last word executed", dbg_r1, 1);
        run(1);
        check("R8 pc after wrap", dbg_pc, 1);
    endtask

    task automatic t_selfmod();
        clear_prog();
        prog[0]  = enc(3'b101, 1'b1, 4'hA);
        prog[1]  = enc(3'b100, 1'b1, 4'h3);
        prog[10] = enc(3'b000, 1'b0, 4'h0);
        boot();
        run(4);
        check("R11 stored word executed r0", dbg_r0, 1);
        check("R11 r1 holds copied word", dbg_r1, 0);
        check("R11 pc", dbg_pc, 4);
    endtask

    initial begin
        #(20 * 200000);
        nfail++;
        ntests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        t_reset_timing();
        t_step();
        t_wrap();
        t_branch();
        t_mem();
        t_spare();
        t_pc_wrap();
        t_selfmod();
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule